// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, for each incoming frame, whether the frame is kept. The six destination address bytes enter one per cycle at the head of the frame, first byte first. The cycle after the sixth byte, the filter gives a one-cycle decision: an accept bit and a class tag that says whether the destination was a single station, a group or the all-ones broadcast address.

Software sets up the filter through a small register port. It holds the station's own address, a four-entry group address table, a promiscuous-mode bit and two reject bits, one for broadcast and one for group frames. A write-and-command pair fills the table, and the same command word can also fetch any entry back. A sticky flag records that a frame was turned away. Software clears the flag by writing a one to it.

Top module: `dest_addr_filter`

## Requirements
- R1: Register select codes on cfgSel: 0 = station address low word, 1 = station address high word, 2 = table staging low word (reads give the fetched entry's low word), 3 = table command, 4 = mode, 5 = control. Address byte k of a destination (k = 0 arrives first) is held in bits 8k+7:8k of {high[15:0], low}. Registers 0, 1 and 4 read back exactly as written.
- R2: A destination whose first byte has bit 0 = 0 and which is not all ones is class 0 (single station). Such a frame is accepted when all 48 bits equal the programmed station address.
- R3: A single-station frame that differs from the programmed address in any bit, including a bit of byte 5, is rejected.
- R4: A destination of six 0xFF bytes is class 2 (broadcast). It is accepted unless reject-broadcast (control bit 2) is set.
- R5: Any other destination whose first byte has bit 0 = 1 is class 1 (group). It is accepted only when it equals a valid table entry and reject-group (control bit 1) is clear.
- R6: A write to register 3 with bit 23 = 0 stores {bits 15:0, staging low word} into the table entry chosen by bits 17:16 and marks that entry valid. After reset all entries are invalid.
- R7: A write to register 3 with bit 23 = 1 copies the chosen entry into the read-back words: register 2 reads its bits 31:0, and register 3 reads its bits 47:32 in 15:0. The entry itself is not changed.
- R8: When mode bit 31 (promiscuous) is set, every frame is accepted, and its class is still reported.
- R9: decValid is high for exactly one cycle, the cycle after the sixth address byte. Bytes that arrive after the sixth and are not marked first produce no further decision.
- R10: A byte marked first always starts a new address, even in the middle of an earlier one. The unfinished address produces no decision.
- R11: rejectFlag is set in the same cycle that a reject decision appears. It stays set until a control write with bit 3 = 1 clears it. A reject decision in the cycle of the clear write wins. Control bit 3 reads as the flag.
- R12: After reset decValid, decAccept and rejectFlag are 0, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A receive byte is present this cycle |
| rxFirst | input | 1 | The present byte is the first destination byte of a frame |
| rxByte | input | 8 | Receive byte |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Read data of the selected register (combinational) |
| decValid | output | 1 | Decision strobe, one cycle |
| decAccept | output | 1 | Frame accepted (valid with decValid) |
| decClass | output | 2 | 0 single station, 1 group, 2 broadcast |
| rejectFlag | output | 1 | Sticky reject status |

## Verification
The bound checker watches, on every cycle, the timing of the decision strobe against its own byte count. It also checks that the class code is always legal, that promiscuous mode always accepts and that reject-broadcast blocks a broadcast. It checks that every reject sets the sticky flag and that the flag holds until a clear write. Only the directed scenarios can show that table entries are stored and fetched at the right index, and that single-station matching is exact down to a bit in the last byte. They also show that fetching an entry leaves it unchanged and that a restart in mid-address discards the partial address.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  localparam int MAC_BYTES = 6;
  localparam int BYTE_BITS = 8;
  localparam int ADDR_BITS = MAC_BYTES * BYTE_BITS;
  localparam int CAP_IDX_W = $clog2(MAC_BYTES + 1);
  localparam int REG_W     = 32;

  localparam logic [2:0] SEL_UC_LO  = 3'd0;
  localparam logic [2:0] SEL_UC_HI  = 3'd1;
  localparam logic [2:0] SEL_MC_LO  = 3'd2;
  localparam logic [2:0] SEL_MC_CMD = 3'd3;
  localparam logic [2:0] SEL_MODE   = 3'd4;
  localparam logic [2:0] SEL_CTRL   = 3'd5;

  localparam int CMD_IDX_LSB = 16;
  localparam int CMD_RD_BIT  = 23;
  localparam int MODE_PROM_BIT = 31;
  localparam int CTRL_REJ_MC_BIT = 1;
  localparam int CTRL_REJ_BC_BIT = 2;
  localparam int CTRL_FLAG_BIT   = 3;

  typedef enum logic [1:0] {
    CLS_UNICAST   = 2'd0,
    CLS_MULTICAST = 2'd1,
    CLS_BROADCAST = 2'd2
  } frameClass_e;

  typedef struct packed {
    logic                 capEn;
    logic [CAP_IDX_W-1:0] capIdx;
    logic                 decide;
  } capStrobe_t;
endpackage

// File: rtl/addr_filt_ctrl.sv
module addr_filt_ctrl
  import addr_filt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxFirst,
  output capStrobe_t strb
);
  localparam logic [CAP_IDX_W-1:0] LAST_IDX = CAP_IDX_W'(MAC_BYTES - 1);

  // 0 = idle, otherwise index of the next byte expected
  logic [CAP_IDX_W-1:0] nextIdx;

  always_comb begin
    strb = '0;
    if (rxValid && rxFirst) begin
      strb.capEn  = 1'b1;
      strb.capIdx = '0;
      strb.decide = (MAC_BYTES == 1);
    end else if (rxValid && nextIdx != '0) begin
      strb.capEn  = 1'b1;
      strb.capIdx = nextIdx;
      strb.decide = (nextIdx == LAST_IDX);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextIdx <= '0;
    end else if (rxValid && rxFirst) begin
      nextIdx <= (MAC_BYTES == 1) ? '0 : CAP_IDX_W'(1);
    end else if (rxValid && nextIdx != '0) begin
      nextIdx <= (nextIdx == LAST_IDX) ? '0 : nextIdx + CAP_IDX_W'(1);
    end
  end
endmodule

// File: rtl/addr_filt_datapath.sv
module addr_filt_datapath
  import addr_filt_pkg::*;
#(
  parameter int MC_ENTRIES = 4,
  localparam int MC_IDX_W = (MC_ENTRIES > 1) ? $clog2(MC_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  capStrobe_t           strb,
  input  logic [BYTE_BITS-1:0] rxByte,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgSel,
  input  logic [REG_W-1:0]     cfgWdata,
  output logic [REG_W-1:0]     cfgRdata,
  output logic                 decValid,
  output logic                 decAccept,
  output logic [1:0]           decClass,
  output logic                 rejectFlag
);
  localparam int HI_BITS = ADDR_BITS - REG_W;

  // captured address bytes and the full address seen at the decision edge
  logic [BYTE_BITS-1:0] addrBytes [MAC_BYTES];
  logic [ADDR_BITS-1:0] frameAddr;

  // programmable state
  logic [REG_W-1:0]   ucLo, ucHi, mcLoStage, modeReg, ctlReg;
  logic [15:0]        cmdUpper;
  logic [REG_W-1:0]   rbLow;
  logic [HI_BITS-1:0] rbHigh;
  logic [ADDR_BITS-1:0] mcEntry [MC_ENTRIES];
  logic [MC_ENTRIES-1:0] mcValid;

  // write decode
  logic wrUcLo, wrUcHi, wrMcLo, wrCmd, wrMode, wrCtl, tblWr, tblRd;
  logic [MC_IDX_W-1:0]  cmdIdx;
  logic [ADDR_BITS-1:0] rdEntry;

  assign wrUcLo = cfgWe && (cfgSel == SEL_UC_LO);
  assign wrUcHi = cfgWe && (cfgSel == SEL_UC_HI);
  assign wrMcLo = cfgWe && (cfgSel == SEL_MC_LO);
  assign wrCmd  = cfgWe && (cfgSel == SEL_MC_CMD);
  assign wrMode = cfgWe && (cfgSel == SEL_MODE);
  assign wrCtl  = cfgWe && (cfgSel == SEL_CTRL);
  assign tblWr  = wrCmd && !cfgWdata[CMD_RD_BIT];
  assign tblRd  = wrCmd &&  cfgWdata[CMD_RD_BIT];
  assign cmdIdx = cfgWdata[CMD_IDX_LSB +: MC_IDX_W];

  // ---------------- address capture ----------------
  for (genvar b = 0; b < MAC_BYTES; b++) begin : g_byte
    logic hitHere;
    assign hitHere = strb.capEn && (strb.capIdx == CAP_IDX_W'(b));
    assign frameAddr[b*BYTE_BITS +: BYTE_BITS] = hitHere ? rxByte : addrBytes[b];
    always_ff @(posedge clk) begin
      if (!rstN)        addrBytes[b] <= '0;
      else if (hitHere) addrBytes[b] <= rxByte;
    end
  end

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ucLo      <= '0;
      ucHi      <= '0;
      mcLoStage <= '0;
      modeReg   <= '0;
      ctlReg    <= '0;
      cmdUpper  <= '0;
    end else begin
      if (wrUcLo) ucLo      <= cfgWdata;
      if (wrUcHi) ucHi      <= cfgWdata;
      if (wrMcLo) mcLoStage <= cfgWdata;
      if (wrMode) modeReg   <= cfgWdata;
      if (wrCtl)  ctlReg    <= cfgWdata & ~(REG_W'(1) << CTRL_FLAG_BIT);
      if (wrCmd)  cmdUpper  <= cfgWdata[REG_W-1:16];
    end
  end

  // ---------------- group address table ----------------
  logic [MC_ENTRIES-1:0] hitVec;

  for (genvar e = 0; e < MC_ENTRIES; e++) begin : g_entry
    logic selHere;
    assign selHere = (cmdIdx == MC_IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mcEntry[e] <= '0;
        mcValid[e] <= 1'b0;
      end else if (tblWr && selHere) begin
        mcEntry[e] <= {cfgWdata[HI_BITS-1:0], mcLoStage};
        mcValid[e] <= 1'b1;
      end
    end
    assign hitVec[e] = mcValid[e] && (mcEntry[e] == frameAddr);
  end

  always_comb begin
    rdEntry = '0;
    for (int e = 0; e < MC_ENTRIES; e++) begin
      if (cmdIdx == MC_IDX_W'(e)) rdEntry = mcEntry[e];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rbLow  <= '0;
      rbHigh <= '0;
    end else if (tblRd) begin
      rbLow  <= rdEntry[REG_W-1:0];
      rbHigh <= rdEntry[ADDR_BITS-1:REG_W];
    end
  end

  // ---------------- decision ----------------
  logic isBcast, isMcast, ucHit, tableHit, promisc, rejMc, rejBc, acceptNext;
  frameClass_e classNext;

  assign isBcast  = &frameAddr;
  assign isMcast  = frameAddr[0];
  assign ucHit    = (frameAddr == {ucHi[HI_BITS-1:0], ucLo});
  assign tableHit = |hitVec;
  assign promisc  = modeReg[MODE_PROM_BIT];
  assign rejMc    = ctlReg[CTRL_REJ_MC_BIT];
  assign rejBc    = ctlReg[CTRL_REJ_BC_BIT];

  always_comb begin
    if (isBcast) begin
      classNext  = CLS_BROADCAST;
      acceptNext = !rejBc;
    end else if (isMcast) begin
      classNext  = CLS_MULTICAST;
      acceptNext = tableHit && !rejMc;
    end else begin
      classNext  = CLS_UNICAST;
      acceptNext = ucHit;
    end
    if (promisc) acceptNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
      decClass  <= CLS_UNICAST;
    end else begin
      decValid <= strb.decide;
      if (strb.decide) begin
        decAccept <= acceptNext;
        decClass  <= classNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             rejectFlag <= 1'b0;
    else if (strb.decide && !acceptNext)   rejectFlag <= 1'b1;
    else if (wrCtl && cfgWdata[CTRL_FLAG_BIT]) rejectFlag <= 1'b0;
  end

  // ---------------- read-back ----------------
  always_comb begin
    case (cfgSel)
      SEL_UC_LO:  cfgRdata = ucLo;
      SEL_UC_HI:  cfgRdata = ucHi;
      SEL_MC_LO:  cfgRdata = rbLow;
      SEL_MC_CMD: cfgRdata = {cmdUpper, rbHigh};
      SEL_MODE:   cfgRdata = modeReg;
      SEL_CTRL:   cfgRdata = ctlReg | (REG_W'(rejectFlag) << CTRL_FLAG_BIT);
      default:    cfgRdata = '0;
    endcase
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import addr_filt_pkg::*;
#(
  parameter int MC_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxFirst,
  input  logic [7:0]  rxByte,
  input  logic        cfgWe,
  input  logic [2:0]  cfgSel,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        decValid,
  output logic        decAccept,
  output logic [1:0]  decClass,
  output logic        rejectFlag
);
  capStrobe_t strb;

  addr_filt_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .rxFirst (rxFirst),
    .strb    (strb)
  );

  addr_filt_datapath #(.MC_ENTRIES(MC_ENTRIES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rxByte     (rxByte),
    .cfgWe      (cfgWe),
    .cfgSel     (cfgSel),
    .cfgWdata   (cfgWdata),
    .cfgRdata   (cfgRdata),
    .decValid   (decValid),
    .decAccept  (decAccept),
    .decClass   (decClass),
    .rejectFlag (rejectFlag)
  );
endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk
  import addr_filt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rxValid,
  input logic        rxFirst,
  input logic        cfgWe,
  input logic [2:0]  cfgSel,
  input logic [31:0] cfgWdata,
  input logic        decValid,
  input logic        decAccept,
  input logic [1:0]  decClass,
  input logic        rejectFlag
);
  // independent byte counter built from the ports
  int  seen;
  logic sixthNow;
  logic promSh, rejBcSh, clearWr;

  assign sixthNow = rxValid && (rxFirst ? (MAC_BYTES == 1) : (seen == MAC_BYTES - 1));
  assign clearWr  = cfgWe && (cfgSel == SEL_CTRL) && cfgWdata[CTRL_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seen    <= 0;
      promSh  <= 1'b0;
      rejBcSh <= 1'b0;
    end else begin
      if (rxValid && rxFirst)             seen <= 1;
      else if (rxValid && seen != 0)      seen <= (seen == MAC_BYTES - 1) ? 0 : seen + 1;
      if (cfgWe && cfgSel == SEL_MODE)    promSh  <= cfgWdata[MODE_PROM_BIT];
      if (cfgWe && cfgSel == SEL_CTRL)    rejBcSh <= cfgWdata[CTRL_REJ_BC_BIT];
    end
  end

  // R9
  dec_after_sixth_chk: assert property (@(posedge clk) disable iff (!rstN)
    sixthNow |=> decValid);
  // R9
  dec_only_after_sixth_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(sixthNow));
  // R2
  class_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> decClass != 2'd3);
  // R8
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(promSh)) |-> decAccept);
  // R4
  bcast_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decClass == 2'd2 && !$past(promSh) && $past(rejBcSh)) |-> !decAccept);
  // R11
  flag_on_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decAccept) |-> rejectFlag);
  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rejectFlag && !clearWr) |=> rejectFlag);
endmodule

bind dest_addr_filter dest_addr_filter_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxValid    (rxValid),
  .rxFirst    (rxFirst),
  .cfgWe      (cfgWe),
  .cfgSel     (cfgSel),
  .cfgWdata   (cfgWdata),
  .decValid   (decValid),
  .decAccept  (decAccept),
  .decClass   (decClass),
  .rejectFlag (rejectFlag)
);

// File: tb/test_dest_addr_filter.sv
module test_dest_addr_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxFirst = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        decValid, decAccept, rejectFlag;
  logic [1:0]  decClass;

  int checks = 0, failures = 0;
  bit finished = 0;

  // bench shadow of the programmed state
  logic [47:0] shUc = '0;
  logic [47:0] shTbl [4];
  logic [3:0]  shValid = '0;
  logic        shProm = 0, shRejMc = 0, shRejBc = 0;

  always #5 clk = ~clk;

  dest_addr_filter i_dest_addr_filter (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxFirst(rxFirst), .rxByte(rxByte),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .decValid(decValid), .decAccept(decAccept), .decClass(decClass),
    .rejectFlag(rejectFlag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [2:0] sel, output logic [31:0] data);
    @(negedge clk);
    cfgSel = sel;
    #1 data = cfgRdata;
  endtask

  task automatic setMode(input logic prom);
    shProm = prom;
    cfgWrite(3'd4, {prom, 31'd0});
  endtask

  task automatic setCtl(input logic rejMc, input logic rejBc, input logic clr);
    shRejMc = rejMc; shRejBc = rejBc;
    cfgWrite(3'd5, {28'd0, clr, rejBc, rejMc, 1'b0});
  endtask

  task automatic progEntry(input int idx, input logic [47:0] a);
    cfgWrite(3'd2, a[31:0]);
    cfgWrite(3'd3, {8'd0, 1'b0, 5'd0, 2'(idx), a[47:32]});
    shTbl[idx] = a; shValid[idx] = 1'b1;
  endtask

  function automatic logic [1:0] expClass(input logic [47:0] a);
    if (&a) return 2'd2;
    if (a[0]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic expAccept(input logic [47:0] a);
    logic hit = 0;
    if (shProm) return 1'b1;
    if (&a) return !shRejBc;
    if (a[0]) begin
      for (int e = 0; e < 4; e++) if (shValid[e] && shTbl[e] == a) hit = 1;
      return hit && !shRejMc;
    end
    return a == shUc;
  endfunction

  // drive six bytes, then check the one-cycle decision
  task automatic sendFrame(input string req, input logic [47:0] a);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      rxValid = 1'b1; rxFirst = (b == 0); rxByte = a[b*8 +: 8];
      if (b > 0) chk({req, " no early decision"}, decValid, 0);
    end
    @(negedge clk);
    rxValid = 1'b0; rxFirst = 1'b0;
    chk({req, " decValid"}, decValid, 1);
    chk({req, " class"}, decClass, expClass(a));
    chk({req, " accept"}, decAccept, expAccept(a));
    @(negedge clk);
    chk({req, " decValid one cycle (R9)"}, decValid, 0);
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R12 decValid", decValid, 0);
    chk("R12 decAccept", decAccept, 0);
    chk("R12 rejectFlag", rejectFlag, 0);
    for (int s = 0; s < 6; s++) begin
      cfgRead(3'(s), d);
      chk("R12 register zero", d, 0);
    end
  endtask

  task automatic testRegisters();
    logic [31:0] d;
    shUc = 48'h665544332210;
    cfgWrite(3'd0, 32'h44332210);
    cfgWrite(3'd1, 32'h00006655);
    cfgRead(3'd0, d); chk("R1 station low readback", d, 32'h44332210);
    cfgRead(3'd1, d); chk("R1 station high readback", d, 32'h00006655);
    setMode(1'b0);
    cfgRead(3'd4, d); chk("R1 mode readback", d, 0);
  endtask

  task automatic testUnicast();
    sendFrame("R2 station match", 48'h665544332210);
    sendFrame("R3 mismatch byte5", 48'h675544332210);
    sendFrame("R3 mismatch byte0", 48'h665544332212);
    chk("R11 flag after reject", rejectFlag, 1);
  endtask

  task automatic testFlag();
    logic [31:0] d;
    cfgRead(3'd5, d); chk("R11 flag visible in control bit 3", d[3], 1);
    setCtl(0, 0, 1);
    chk("R11 flag cleared", rejectFlag, 0);
    sendFrame("R2 accept keeps flag clear", 48'h665544332210);
    chk("R11 flag stays clear on accept", rejectFlag, 0);
  endtask

  task automatic testBroadcast();
    sendFrame("R4 broadcast accepted", 48'hFFFFFFFFFFFF);
    setCtl(0, 1, 0);
    sendFrame("R4 broadcast rejected", 48'hFFFFFFFFFFFF);
    setCtl(0, 0, 1);
  endtask

  task automatic testMulticast();
    sendFrame("R6 empty table rejects group", 48'hAABBCCDDEE01);
    progEntry(0, 48'hAABBCCDDEE01);
    progEntry(3, 48'h0000005E0001);
    sendFrame("R5 group hit entry0", 48'hAABBCCDDEE01);
    sendFrame("R5 group hit entry3", 48'h0000005E0001);
    sendFrame("R5 group miss", 48'hAABBCCDDEE03);
    setCtl(1, 0, 0);
    sendFrame("R5 reject-group blocks hit", 48'hAABBCCDDEE01);
    setCtl(0, 0, 1);
  endtask

  task automatic testTableRead();
    logic [31:0] d;
    progEntry(2, 48'h123456789A0B);
    cfgWrite(3'd3, {8'd0, 1'b1, 5'd0, 2'd2, 16'hBEEF});
    cfgRead(3'd2, d); chk("R7 read-back low", d, 32'h56789A0B);
    cfgRead(3'd3, d); chk("R7 read-back high", d[15:0], 16'h1234);
    sendFrame("R7 entry unchanged by fetch", 48'h123456789A0B);
    cfgWrite(3'd3, {8'd0, 1'b1, 5'd0, 2'd1, 16'h0000});
    cfgRead(3'd3, d); chk("R6 invalid entry1 reads zero", d[15:0], 16'h0000);
  endtask

  task automatic testPromisc();
    setCtl(1, 1, 0);
    setMode(1'b1);
    sendFrame("R8 promiscuous stranger", 48'h010203040506);
    sendFrame("R8 promiscuous broadcast", 48'hFFFFFFFFFFFF);
    sendFrame("R8 promiscuous group miss", 48'h010203040507);
    setMode(1'b0);
    setCtl(0, 0, 1);
  endtask

  task automatic testTrailingBytes();
    sendFrame("R9 base frame", 48'h665544332210);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      rxValid = 1'b1; rxFirst = 1'b0; rxByte = 8'hFF;
      chk("R9 trailing byte no decision", decValid, 0);
    end
    @(negedge clk);
    rxValid = 1'b0;
    chk("R9 trailing byte no decision", decValid, 0);
  endtask

  task automatic testRestart();
    logic [47:0] a = 48'hFFFFFFFFFFFF;
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      rxValid = 1'b1; rxFirst = (b == 0); rxByte = a[b*8 +: 8];
    end
    sendFrame("R10 restart mid-address", 48'h665544332210);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegisters();
    testUnicast();
    testFlag();
    testBroadcast();
    testMulticast();
    testTableRead();
    testPromisc();
    testTrailingBytes();
    testRestart();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule